// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one processor's cache controller and tracks a single atomic-sequence reservation. A load-linked marks the reservation valid and records the cache block it touched. Three events can take the reservation away before the matching store-conditional arrives: another agent's invalidation of that block seen on the snoop port, the cache evicting that block, or the operating system switching context. The store-conditional is judged against the reservation. A passing one is reported as successful and, when the line is not already held with write permission, asks the controller for a bus invalidation. A failing one is reported as failed and never produces bus traffic.

After each failed store-conditional an exponential backoff window opens. Its length doubles with every consecutive failure, up to a ceiling. Software or the pipeline can hold off retries while the busy output is high. All results appear one clock after the request.

Top module: `llsc_monitor`

## Requirements
- R1: After synchronous reset, rsv_valid, resp_valid, resp_ok, bus_inv_req and backoff_busy are all 0.
- R2: A load-linked makes rsv_valid 1 on the next cycle and records its block address. The block address is the address with its low log2(BLOCK_BYTES) bits ignored, 6 bits by default.
- R3: A snooped invalidation whose block matches the recorded block clears rsv_valid on the next cycle. An invalidation of any other block leaves it unchanged.
- R4: A replacement of the recorded block clears rsv_valid on the next cycle. A replacement of any other block leaves it unchanged.
- R5: A context switch clears rsv_valid on the next cycle.
- R6: A store-conditional gives resp_valid=1 on the next cycle, and only then. resp_ok is 1 only if rsv_valid was 1 and the store's block equals the recorded block. Otherwise resp_ok is 0.
- R7: bus_inv_req is 1 exactly when resp_ok is 1 and sc_line_owned was 0 with the request. A failed store-conditional never raises bus_inv_req.
- R8: Every store-conditional, whether it passes or fails, clears rsv_valid on the next cycle unless a load-linked comes in the same cycle.
- R9: If a clearing event (a matching invalidation, a matching replacement or a context switch) arrives in the same cycle as a store-conditional, the store-conditional fails.
- R10: A failed store-conditional raises the backoff exponent e by one, saturating at MAX_EXP (default 4), starting from 0 after reset. backoff_busy is then high for exactly 2^e cycles, starting the cycle the failure is reported. A successful store-conditional resets e to 0.
- R11: A load-linked in the same cycle as any clearing event or store-conditional wins: the reservation becomes valid for the load-linked's block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_valid | input | 1 | Load-linked issued this cycle |
| ll_addr | input | ADDR_W | Load-linked byte address |
| sc_valid | input | 1 | Store-conditional issued this cycle |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| sc_line_owned | input | 1 | Cache already holds the SC's line with write permission |
| snoop_inv_valid | input | 1 | Snooped invalidating transaction this cycle |
| snoop_inv_addr | input | ADDR_W | Address of the snooped invalidation |
| repl_valid | input | 1 | Cache evicts a block this cycle |
| repl_addr | input | ADDR_W | Address of the evicted block |
| ctx_switch | input | 1 | Context switch this cycle |
| rsv_valid | output | 1 | Reservation currently held |
| resp_valid | output | 1 | Store-conditional result is present |
| resp_ok | output | 1 | Store-conditional succeeded |
| bus_inv_req | output | 1 | Request a bus invalidation for the successful store |
| backoff_busy | output | 1 | Backoff window running after a failure |

## Verification
The bench aims at the races: an invalidation landing in the same cycle as the store-conditional, which a design that updated the flag first would let succeed, and a load-linked arriving together with a clear, which a design that let the clear win would turn into a spurious failure. It probes offsets inside the reserved block and addresses just past it. A design comparing full addresses would then fail good stores, and one masking too many bits would keep reservations it should lose. A run of consecutive failures walks the backoff window through every doubling to the ceiling and back to the minimum after a success. This catches off-by-one window lengths and a missing saturation. Each failure is also checked for silence on the bus-request output.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        RSV_HOLD  = 2'd0,
        RSV_SET   = 2'd1,
        RSV_CLEAR = 2'd2
    } rsv_op_t;

    typedef struct packed {
        logic valid;
        logic ok;
        logic bus;
    } sc_verdict_t;

endpackage

// File: rtl/llsc_rsv_reg.sv
module llsc_rsv_reg
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  rsv_op_t           op,
    input  logic [ADDR_W-1:0] set_blk,
    output logic              flag,
    output logic [ADDR_W-1:0] lock_blk
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag     <= 1'b0;
            lock_blk <= '0;
        end else begin
            case (op)
                RSV_SET: begin
                    flag     <= 1'b1;
                    lock_blk <= set_blk;
                end
                RSV_CLEAR: flag <= 1'b0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/llsc_sc_eval.sv
module llsc_sc_eval
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6
) (
    input  logic              flag,
    input  logic [ADDR_W-1:0] lock_blk,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              sc_line_owned,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic              repl_valid,
    input  logic [ADDR_W-1:0] repl_addr,
    input  logic              ctx_switch,
    output rsv_op_t           op,
    output logic [ADDR_W-1:0] set_blk,
    output sc_verdict_t       verdict
);

    localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

    logic inv_hit, repl_hit, kill, sc_hit;

    always_comb begin
        inv_hit  = inv_valid  && ((inv_addr  & BLK_MASK) == lock_blk);
        repl_hit = repl_valid && ((repl_addr & BLK_MASK) == lock_blk);
        kill     = inv_hit || repl_hit || ctx_switch;
        sc_hit   = (sc_addr & BLK_MASK) == lock_blk;

        verdict.valid = sc_valid;
        verdict.ok    = sc_valid && flag && sc_hit && !kill;
        verdict.bus   = verdict.ok && !sc_line_owned;

        set_blk = ll_addr & BLK_MASK;
        if (ll_valid)              op = RSV_SET;
        else if (sc_valid || kill) op = RSV_CLEAR;
        else                       op = RSV_HOLD;
    end

endmodule

// File: rtl/llsc_backoff.sv
module llsc_backoff #(
    parameter int MAX_EXP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fail_pulse,
    input  logic succ_pulse,
    output logic busy
);

    localparam int EXP_W = $clog2(MAX_EXP + 1);
    localparam int CNT_W = MAX_EXP + 1;

    logic [EXP_W-1:0] exp_q, exp_inc;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        exp_inc = (exp_q == EXP_W'(MAX_EXP)) ? exp_q : exp_q + EXP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q <= '0;
            cnt_q <= '0;
        end else if (fail_pulse) begin
            exp_q <= exp_inc;
            cnt_q <= CNT_W'(1) << exp_inc;
        end else begin
            if (succ_pulse)  exp_q <= '0;
            if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 64,
    parameter int MAX_EXP     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              sc_line_owned,
    input  logic              snoop_inv_valid,
    input  logic [ADDR_W-1:0] snoop_inv_addr,
    input  logic              repl_valid,
    input  logic [ADDR_W-1:0] repl_addr,
    input  logic              ctx_switch,
    output logic              rsv_valid,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic              bus_inv_req,
    output logic              backoff_busy
);

    localparam int OFF_W = $clog2(BLOCK_BYTES);

    rsv_op_t           op;
    logic [ADDR_W-1:0] set_blk, lock_blk;
    logic              flag;
    sc_verdict_t       verdict, resp_q;

    llsc_rsv_reg #(.ADDR_W(ADDR_W)) u_rsv (
        .clk(clk), .rst(rst), .op(op), .set_blk(set_blk),
        .flag(flag), .lock_blk(lock_blk)
    );

    llsc_sc_eval #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_eval (
        .flag(flag), .lock_blk(lock_blk),
        .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_line_owned(sc_line_owned),
        .inv_valid(snoop_inv_valid), .inv_addr(snoop_inv_addr),
        .repl_valid(repl_valid), .repl_addr(repl_addr),
        .ctx_switch(ctx_switch),
        .op(op), .set_blk(set_blk), .verdict(verdict)
    );

    llsc_backoff #(.MAX_EXP(MAX_EXP)) u_backoff (
        .clk(clk), .rst(rst),
        .fail_pulse(verdict.valid && !verdict.ok),
        .succ_pulse(verdict.ok),
        .busy(backoff_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) resp_q <= '0;
        else     resp_q <= verdict;
    end

    assign rsv_valid   = flag;
    assign resp_valid  = resp_q.valid;
    assign resp_ok     = resp_q.ok;
    assign bus_inv_req = resp_q.bus;

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk (
    input logic clk,
    input logic rst,
    input logic ll_valid,
    input logic sc_valid,
    input logic ctx_switch,
    input logic rsv_valid,
    input logic resp_valid,
    input logic resp_ok,
    input logic bus_inv_req,
    input logic backoff_busy
);

    p_fail_silent_r7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ok) |-> !bus_inv_req);

    p_bus_needs_ok_r7: assert property (@(posedge clk) disable iff (rst)
        bus_inv_req |-> resp_ok);

    p_sc_resp_r6: assert property (@(posedge clk) disable iff (rst)
        sc_valid |=> resp_valid);

    p_idle_no_resp_r6: assert property (@(posedge clk) disable iff (rst)
        !sc_valid |=> !resp_valid);

    p_no_rsv_fail_r6: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && !rsv_valid) |=> !resp_ok);

    p_ll_sets_r2: assert property (@(posedge clk) disable iff (rst)
        ll_valid |=> rsv_valid);

    p_ctx_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (ctx_switch && !ll_valid) |=> !rsv_valid);

    p_sc_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && !ll_valid) |=> !rsv_valid);

    p_fail_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ok) |-> backoff_busy);

endmodule

bind llsc_monitor llsc_monitor_chk i_chk (
    .clk(clk), .rst(rst), .ll_valid(ll_valid), .sc_valid(sc_valid),
    .ctx_switch(ctx_switch), .rsv_valid(rsv_valid), .resp_valid(resp_valid),
    .resp_ok(resp_ok), .bus_inv_req(bus_inv_req), .backoff_busy(backoff_busy)
);

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;

    localparam int AW = 32;
    localparam logic [AW-1:0] MASK = ~32'h3F;
    localparam int MAXE = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ll_valid = 0, sc_valid = 0, sc_line_owned = 0;
    logic snoop_inv_valid = 0, repl_valid = 0, ctx_switch = 0;
    logic [AW-1:0] ll_addr = '0, sc_addr = '0, snoop_inv_addr = '0, repl_addr = '0;
    logic rsv_valid, resp_valid, resp_ok, bus_inv_req, backoff_busy;

    int vectors = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    bit m_flag = 0;
    logic [AW-1:0] m_lock = '0;
    int m_exp = 0, m_cnt = 0;
    bit m_rv = 0, m_ok = 0, m_bus = 0;

    always #10 clk = ~clk;

    llsc_monitor i_llsc_monitor (
        .clk(clk), .rst(rst),
        .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_line_owned(sc_line_owned),
        .snoop_inv_valid(snoop_inv_valid), .snoop_inv_addr(snoop_inv_addr),
        .repl_valid(repl_valid), .repl_addr(repl_addr),
        .ctx_switch(ctx_switch),
        .rsv_valid(rsv_valid), .resp_valid(resp_valid), .resp_ok(resp_ok),
        .bus_inv_req(bus_inv_req), .backoff_busy(backoff_busy)
    );

    task automatic model_step();
        bit kill, ok;
        kill = ctx_switch
            || (snoop_inv_valid && ((snoop_inv_addr & MASK) == m_lock))
            || (repl_valid && ((repl_addr & MASK) == m_lock));
        ok = sc_valid && m_flag && ((sc_addr & MASK) == m_lock) && !kill;
        m_rv = sc_valid;
        m_ok = ok;
        m_bus = ok && !sc_line_owned;
        if (sc_valid && !ok) begin
            m_exp = (m_exp < MAXE) ? m_exp + 1 : MAXE;
            m_cnt = 1 << m_exp;
        end else begin
            if (ok) m_exp = 0;
            if (m_cnt > 0) m_cnt--;
        end
        if (ll_valid) begin
            m_flag = 1;
            m_lock = ll_addr & MASK;
        end else if (sc_valid || kill) begin
            m_flag = 0;
        end
    endtask

    task automatic compare();
        vectors++;
        if (rsv_valid !== m_flag || resp_valid !== m_rv || resp_ok !== m_ok ||
            bus_inv_req !== m_bus || backoff_busy !== (m_cnt != 0)) begin
            errors++;
            $display("FAIL %s: got rsv=%b rv=%b ok=%b bus=%b busy=%b exp rsv=%b rv=%b ok=%b bus=%b busy=%b",
                cur_req, rsv_valid, resp_valid, resp_ok, bus_inv_req, backoff_busy,
                m_flag, m_rv, m_ok, m_bus, (m_cnt != 0));
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        ll_valid = 0; sc_valid = 0; sc_line_owned = 0;
        snoop_inv_valid = 0; repl_valid = 0; ctx_switch = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic do_ll(input logic [AW-1:0] a);
        ll_valid = 1; ll_addr = a; cyc();
    endtask

    task automatic do_sc(input logic [AW-1:0] a, input bit own);
        sc_valid = 1; sc_addr = a; sc_line_owned = own; cyc();
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        cur_req = "R1"; compare();
        idle(1);

        cur_req = "R2"; do_ll(32'h1000); do_sc(32'h1024, 0); idle(1);
        cur_req = "R7"; do_ll(32'h2000); do_sc(32'h2010, 1); idle(1);
        cur_req = "R6"; do_sc(32'h2000, 0); idle(3);
        cur_req = "R6"; do_ll(32'h9000); do_sc(32'h9040, 0); idle(5);

        cur_req = "R3"; do_ll(32'h3000);
        snoop_inv_valid = 1; snoop_inv_addr = 32'h3038; cyc();
        do_sc(32'h3000, 0); idle(10);
        cur_req = "R3"; do_ll(32'h4000);
        snoop_inv_valid = 1; snoop_inv_addr = 32'h4040; cyc();
        do_sc(32'h403F, 0); idle(2);

        cur_req = "R4"; do_ll(32'h5000);
        repl_valid = 1; repl_addr = 32'h5004; cyc();
        idle(1);
        do_ll(32'h5000);
        repl_valid = 1; repl_addr = 32'h6000; cyc();
        do_sc(32'h5000, 0); idle(20);

        cur_req = "R5"; do_ll(32'h6000);
        ctx_switch = 1; cyc();
        do_sc(32'h6000, 0); idle(2);

        cur_req = "R9"; do_ll(32'h7000);
        sc_valid = 1; sc_addr = 32'h7000;
        snoop_inv_valid = 1; snoop_inv_addr = 32'h7020; cyc();
        idle(20);

        cur_req = "R8"; do_ll(32'h7100); do_sc(32'h7100, 0);
        do_sc(32'h7100, 0); idle(4);

        cur_req = "R11"; ll_valid = 1; ll_addr = 32'h8000; ctx_switch = 1; cyc();
        do_sc(32'h8008, 0);
        do_ll(32'h8100);
        ll_valid = 1; ll_addr = 32'h8200; sc_valid = 1; sc_addr = 32'h8100; cyc();
        do_sc(32'h8200, 0); idle(2);

        cur_req = "R10";
        for (int k = 0; k < 6; k++) begin
            do_sc(32'hA000, 0);
            idle(18);
        end
        do_ll(32'hA000); do_sc(32'hA000, 0);
        do_sc(32'hA000, 0); idle(4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule